// File: doc/BRIEF.md
# Programmable Auxiliary Clock Divider

This block derives a secondary clock from the main system clock and sends it to a pad. The divisor is an integer from 1 to 64, taken from a 6-bit field. The output keeps an exact 50% duty cycle at every divisor, including odd ones. A divisor of 1 passes the system clock straight through.

A 2-bit control field sets how the pad is driven. It can select full or half drive strength, or it can switch the output off, which parks it high. While the PLL is acquiring lock, the output is parked low instead, unless the backup clock is selected. Divisor changes take effect only at a period boundary, so no runt pulse is produced. Leaving a parked state restarts the divider, so the first period after release is full length.

Top module: `auxclk_divider`

## Requirements
- R1: While reset is active, `aux_clk` is 0. After reset, the first output period is 64 system clocks long, whatever value `div_sel` holds.
- R2: The divisor is `div_sel + 1`. Field value 0 divides by 1, and field value 63 divides by 64. The output period is that many system clocks.
- R3: For an even divisor N, the output rises on a system clock rising edge and stays high for N/2 clocks, then low for N/2 clocks.
- R4: For an odd divisor N of 3 or more, the output rises half a clock after a rising edge and stays high for N/2 clocks and low for N/2 clocks, measured in half-clock steps.
- R5: With a divisor of 1, `aux_clk` follows `clk`.
- R6: A new divisor is taken only when the current period ends. The period in progress completes with the old divisor, and the new divisor starts at the next output rise. The low phase of that boundary period is N_old − a_old + a_new half-clocks, where a is 1 for odd divisors of 3 or more and 0 otherwise.
- R7: Control value 2 or 3 (bit 1 set) forces `aux_clk` to 1, starting from the next rising edge of `clk`.
- R8: When `pll_acq` is 1 and `bkup_sel` is 0, `aux_clk` is forced to 0 from the next rising edge. This takes priority over R7.
- R9: When `bkup_sel` is 1, `pll_acq` has no effect, and the output keeps running at its divisor.
- R10: When a forced state is removed, the divider restarts from count zero, so the first output period is full length with the full high phase.
- R11: `drv_code` is 2'b11 (full strength) for control value 1, 2'b10 (half strength) for control value 0, and 2'b00 (driver off) when control bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel | input | 6 | Divisor minus one |
| out_ctl | input | 2 | Drive control: 0 half strength, 1 full strength, 2 or 3 disabled (output high) |
| pll_acq | input | 1 | PLL is acquiring lock |
| bkup_sel | input | 1 | Backup clock selected; masks `pll_acq` |
| aux_clk | output | 1 | Divided clock |
| drv_code | output | 2 | Pad driver code |

## Verification
The divisor reload and a change in output phase alignment can land on the same system clock edge. A counter wrap that loads a new divisor is also the edge at which the output rises, or half a clock before it. When odd and even divisors alternate, the rise moves by half a clock. The bench writes the field just after an observed output rise, so the reload falls on the next wrap. It then measures the high and low widths of that boundary period in half-clock samples and compares them against widths computed from both divisors. Parity changes, entry and exit from bypass, and reload out of the reset default are all exercised this way.

// File: rtl/auxclk_divider.sv
`timescale 1ns/1ps
module auxclk_divider #(
  parameter int CW = 6,
  localparam int NW = CW + 1,
  localparam int NMAX = 1 << CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] div_sel,
  input  logic [1:0]    out_ctl,
  input  logic          pll_acq,
  input  logic          bkup_sel,
  output logic          aux_clk,
  output logic [1:0]    drv_code
);
  typedef enum logic [1:0] {S_RUN, S_LOW, S_HIGH} st_t;
  localparam logic [NW-1:0] ONE = NW'(1);

  st_t           st;
  logic [NW-1:0] n_act, cnt;
  logic          q_pos, q_neg;

  wire           lo_req = pll_acq & ~bkup_sel;
  wire           hi_req = out_ctl[1];
  wire [NW-1:0]  n_new  = {1'b0, div_sel} + ONE;
  wire [NW-1:0]  half   = (n_act + ONE) >> 1;
  wire           wrap   = (cnt == n_act - ONE);
  wire [NW-1:0]  cnt_nx = wrap ? '0 : cnt + ONE;
  wire           bypass = (n_act == ONE);
  wire           odd    = n_act[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_LOW;
      n_act <= NW'(NMAX);
      cnt   <= '0;
      q_pos <= 1'b0;
    end else if (lo_req) begin
      st    <= S_LOW;
      cnt   <= '0;
      q_pos <= 1'b0;
    end else if (hi_req) begin
      st    <= S_HIGH;
      cnt   <= '0;
      q_pos <= 1'b0;
    end else if (st != S_RUN) begin
      st    <= S_RUN;
      cnt   <= '0;
      q_pos <= 1'b1;
    end else begin
      cnt   <= cnt_nx;
      q_pos <= wrap | (cnt_nx < half);
      if (wrap) n_act <= n_new;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_neg <= 1'b0;
    else        q_neg <= bypass ? 1'b0 : q_pos;
  end

  assign aux_clk = (st == S_HIGH) ? 1'b1 :
                   (st == S_LOW)  ? 1'b0 :
                   bypass         ? clk  :
                   odd            ? (q_pos & q_neg) : q_pos;

  assign drv_code = out_ctl[1] ? 2'b00 : {1'b1, out_ctl[0]};

  logic pv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  assert_force_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pv && $past(lo_req) |-> !aux_clk);

  assert_force_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pv && $past(hi_req && !lo_req) |-> aux_clk);

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < n_act);

  assert_div_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pv && (n_act != $past(n_act)) |-> cnt == '0);
endmodule

// File: tb/sim_auxclk_divider.sv
`timescale 1ns/1ps
module sim_auxclk_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] div_sel = 6'd2;
  logic [1:0] out_ctl = 2'b01;
  logic       pll_acq = 1'b0;
  logic       bkup_sel = 1'b0;
  wire        aux_clk;
  wire  [1:0] drv_code;

  auxclk_divider u0 (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .out_ctl(out_ctl),
    .pll_acq(pll_acq), .bkup_sel(bkup_sel), .aux_clk(aux_clk), .drv_code(drv_code)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, cur = 64;
  int exp_n[$], exp_lo[$];
  string exp_tag[$];
  bit mon_en = 1'b1, have = 1'b0;
  logic prev = 1'b0;
  int hi = 0, lo = 0;
  event rose;

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic sample_one();
    logic a;
    a = aux_clk;
    if (!mon_en) begin
      have = 1'b0;
      prev = a;
      return;
    end
    if (a && !prev) begin
      if (have && exp_n.size() > 0) begin
        int n, l;
        string t;
        n = exp_n.pop_front();
        l = exp_lo.pop_front();
        t = exp_tag.pop_front();
        chk(hi == n, {t, " high"}, hi, n);
        chk(lo == l, {t, " low"}, lo, l);
      end
      have = 1'b1;
      hi = 0;
      lo = 0;
      -> rose;
    end
    if (a) hi++; else lo++;
    prev = a;
  endtask

  initial forever begin
    @(posedge clk); #1 sample_one();
    @(negedge clk); #1 sample_one();
  end

  function automatic int off(int n);
    return (n > 1 && n % 2 == 1) ? 1 : 0;
  endfunction

  task automatic push(int n, int l, string t);
    exp_n.push_back(n);
    exp_lo.push_back(l);
    exp_tag.push_back(t);
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && exp_n.size() > 0; i++) @(posedge clk);
    if (exp_n.size() > 0) begin
      chk(1'b0, "scoreboard drain timeout", exp_n.size(), 0);
      exp_n.delete(); exp_lo.delete(); exp_tag.delete();
    end
  endtask

  task automatic change(int nn, string t, int reps);
    drain();
    @rose;
    div_sel = 6'(nn - 1);
    push(cur, cur - off(cur) + off(nn), {"R6 boundary into ", t});
    for (int i = 0; i < reps; i++) push(nn, nn, t);
    cur = nn;
    drain();
  endtask

  task automatic hold_check(logic lvl, int halves, string t);
    int miss;
    miss = 0;
    for (int i = 0; i < halves; i++) begin
      @(clk); #1;
      if (aux_clk !== lvl) miss++;
    end
    chk(miss == 0, t, miss, 0);
  endtask

  task automatic drive_step();
    @(posedge clk); #0.5;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    push(64, 65, "R1 reset default period");
    push(3, 3, "R2 field 2 gives 3, R4 odd");
    push(3, 3, "R4 odd 3");
    repeat (3) @(posedge clk);
    #1;
    chk(aux_clk === 1'b0, "R1 low in reset", aux_clk, 0);
    chk(drv_code == 2'b11, "R11 full strength", drv_code, 3);
    drive_step();
    rst_n = 1'b1;
    drain();
    cur = 3;

    change(4, "R3 even 4", 2);
    change(7, "R4 odd 7", 2);
    change(1, "R5 bypass", 3);
    change(2, "R3 even 2", 2);
    change(64, "R2 field 63 gives 64", 1);
    change(5, "R4 odd 5", 2);

    drive_step();
    pll_acq = 1'b1;
    bkup_sel = 1'b1;
    push(5, 5, "R9 lock flag masked");
    push(5, 5, "R9 lock flag masked");
    drain();

    drive_step();
    mon_en = 1'b0;
    bkup_sel = 1'b0;
    out_ctl = 2'b10;
    repeat (2) @(posedge clk);
    hold_check(1'b0, 20, "R8 low wins over disable");

    drive_step();
    pll_acq = 1'b0;
    repeat (2) @(posedge clk);
    hold_check(1'b1, 20, "R7 disabled holds high");
    chk(drv_code == 2'b00, "R11 driver off", drv_code, 0);

    drive_step();
    out_ctl = 2'b01;
    pll_acq = 1'b1;
    repeat (2) @(posedge clk);
    hold_check(1'b0, 10, "R8 lock acquisition low");
    #0.2;
    chk(drv_code == 2'b11, "R11 full strength", drv_code, 3);

    drive_step();
    out_ctl = 2'b00;
    #0.2;
    chk(drv_code == 2'b10, "R11 half strength", drv_code, 2);

    drive_step();
    push(5, 5, "R10 first period after release");
    push(5, 5, "R10 second period");
    pll_acq = 1'b0;
    mon_en = 1'b1;
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule